// File: doc/BRIEF.md
# CR8 Task-Priority Shadow Controller

This block serves guest reads and writes of the 4-bit CR8 task-priority value on a processor that supports hardware virtualization. Three control bits choose how each access is handled: use-shadow, load-exiting and store-exiting. A 32-bit threshold field is also an input. Each cycle the block takes at most one guest access, either a read or a write with 4-bit data. Depending on the controls, the access is served from a shadow byte kept for the virtual APIC page, served from a native CR8 register, or turned into a VM-exit pulse with a 2-bit reason code.

The shadow priority sits in the upper nibble of the page byte at offset 80H. A host port writes the whole byte and always shows its current value. A shadowed write that lowers the priority below the threshold nibble still updates the shadow, and then raises a trap-like exit. This lets the monitor react after the guest has already changed its priority.

All guest-visible results appear one clock after the access is presented.

Top module: `tpr_shadow_ctrl`

## Requirements
- R1: On synchronous reset, the following all become zero: the page byte (`host_rdata`), the native register (`native_cr8`), `exit_pulse`, `exit_reason`, `rd_valid`, `rd_data` and `acc_err`.
- R2: The threshold comparison uses only `thresh_field[3:0]`. Bits 31:4 have no effect on any output.
- R3: A lone read with store-exiting set gives `exit_pulse`=1 and `exit_reason`=2'b01 on the next cycle, with `rd_valid`=0. The use-shadow setting does not change this.
- R4: A lone read with use-shadow set and store-exiting clear gives `rd_valid`=1 on the next cycle, with `rd_data` equal to page byte bits 7:4 as they stood when the read was presented. No exit is raised. `rd_data` is zero whenever `rd_valid` is 0.
- R5: A lone write with load-exiting set gives `exit_pulse`=1 and `exit_reason`=2'b10 on the next cycle. The page byte and the native register stay unchanged.
- R6: A lone write with use-shadow set and load-exiting clear replaces page byte bits 7:4 with the written value. Bits 3:0 keep their previous value.
- R7: A shadowed write whose value is strictly below `thresh_field[3:0]` gives `exit_pulse`=1 and `exit_reason`=2'b11 on the next cycle, and the shadow still holds the new value. A value equal to or above the threshold raises no exit.
- R8: When use-shadow is clear and the matching exiting control is clear, the access goes to the native register instead. A write loads `native_cr8`. A read returns `native_cr8` with `rd_valid`=1. No exit is raised and the page byte is unchanged.
- R9: A read and a write presented together give `acc_err`=1 on the next cycle. Neither access is performed: no exit, no `rd_valid`, and no change to the page byte or the native register.
- R10: A host write loads all 8 bits of the page byte at the clock edge, and `host_rdata` shows the stored byte with no delay. If a host write and a shadowed guest write arrive in the same cycle, the host value is stored, and the guest write's exit decision is unaffected.
- R11: `exit_reason` is 2'b00 whenever `exit_pulse` is 0. `exit_pulse` is high only in the cycle after an exiting access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_use_shadow | input | 1 | Serve CR8 accesses from the shadow byte |
| ctl_load_exit | input | 1 | CR8 writes cause an exit |
| ctl_store_exit | input | 1 | CR8 reads cause an exit |
| thresh_field | input | 32 | Threshold field; only bits 3:0 are used |
| acc_rd | input | 1 | Guest CR8 read request |
| acc_wr | input | 1 | Guest CR8 write request |
| acc_wdata | input | 4 | Guest CR8 write value |
| rd_valid | output | 1 | Read result valid (one cycle after the request) |
| rd_data | output | 4 | Read result |
| exit_pulse | output | 1 | VM-exit indication |
| exit_reason | output | 2 | 01 read exit, 10 write exit, 11 below-threshold trap |
| acc_err | output | 1 | Read and write were requested in the same cycle |
| host_wr | input | 1 | Host write of the page byte |
| host_wdata | input | 8 | Host write value |
| host_rdata | output | 8 | Current page byte at offset 80H |
| native_cr8 | output | 4 | Native CR8 register value |

## Verification
The bench checks the threshold boundary at equality. A strict-versus-non-strict comparison error would trap on equality or fail to trap one step below. It sets the threshold's upper bits, which a design that compares the whole field would wrongly react to. It drives collisions that a wrong priority order would mishandle: store-exiting with use-shadow, host writes racing guest writes, and simultaneous read and write. Those mistakes would show up as a shadowed read where an exit belongs, a lost host value, or a half-performed access. It also preserves the lower nibble of the page byte across guest writes and holds the shadow stable under load-exiting, where a sloppy write path would corrupt state.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

    localparam int PRIO_W_D  = 4;
    localparam int THR_W_D   = 32;
    localparam int BYTE_W_D  = 8;

    typedef enum logic [1:0] {
        EXIT_NONE  = 2'd0,
        EXIT_READ  = 2'd1,
        EXIT_WRITE = 2'd2,
        EXIT_TRAP  = 2'd3
    } exit_code_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_ERR,
        ACT_RD_EXIT,
        ACT_RD_SHADOW,
        ACT_RD_NATIVE,
        ACT_WR_EXIT,
        ACT_WR_SHADOW,
        ACT_WR_NATIVE
    } act_e;

    typedef struct packed {
        logic use_shadow;
        logic load_exit;
        logic store_exit;
    } ctl_t;

    typedef struct packed {
        act_e act;
        logic below;
    } dec_t;

    function automatic exit_code_e exit_for(dec_t d);
        case (d.act)
            ACT_RD_EXIT:   return EXIT_READ;
            ACT_WR_EXIT:   return EXIT_WRITE;
            ACT_WR_SHADOW: return d.below ? EXIT_TRAP : EXIT_NONE;
            default:       return EXIT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/tpr_decode.sv
module tpr_decode
    import tpr_pkg::*;
#(
    parameter int PRIO_W = PRIO_W_D
) (
    input  ctl_t              ctl,
    input  logic              rd,
    input  logic              wr,
    input  logic [PRIO_W-1:0] wdata,
    input  logic [PRIO_W-1:0] thr,
    output dec_t              dec
);

    always_comb begin
        dec.below = (wdata < thr);
        if (rd && wr)
            dec.act = ACT_ERR;
        else if (rd)
            dec.act = ctl.store_exit ? ACT_RD_EXIT :
                      ctl.use_shadow ? ACT_RD_SHADOW : ACT_RD_NATIVE;
        else if (wr)
            dec.act = ctl.load_exit  ? ACT_WR_EXIT :
                      ctl.use_shadow ? ACT_WR_SHADOW : ACT_WR_NATIVE;
        else
            dec.act = ACT_IDLE;
    end

endmodule

// File: rtl/tpr_store.sv
module tpr_store #(
    parameter int BYTE_W = tpr_pkg::BYTE_W_D,
    parameter int PRIO_W = tpr_pkg::PRIO_W_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [BYTE_W-1:0] host_val,
    input  logic              sh_we,
    input  logic [PRIO_W-1:0] sh_val,
    input  logic              nat_we,
    input  logic [PRIO_W-1:0] nat_val,
    output logic [BYTE_W-1:0] page_q,
    output logic [PRIO_W-1:0] native_q
);

    localparam int LOW_W = BYTE_W - PRIO_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q   <= '0;
            native_q <= '0;
        end else begin
            if (host_we)
                page_q <= host_val;
            else if (sh_we)
                page_q <= {sh_val, page_q[LOW_W-1:0]};
            if (nat_we)
                native_q <= nat_val;
        end
    end

endmodule

// File: rtl/tpr_shadow_ctrl.sv
module tpr_shadow_ctrl
    import tpr_pkg::*;
#(
    parameter int PRIO_W = PRIO_W_D,
    parameter int THR_W  = THR_W_D,
    parameter int BYTE_W = BYTE_W_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_use_shadow,
    input  logic              ctl_load_exit,
    input  logic              ctl_store_exit,
    input  logic [THR_W-1:0]  thresh_field,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [PRIO_W-1:0] acc_wdata,
    output logic              rd_valid,
    output logic [PRIO_W-1:0] rd_data,
    output logic              exit_pulse,
    output logic [1:0]        exit_reason,
    output logic              acc_err,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic [PRIO_W-1:0] native_cr8
);

    localparam int PRIO_LSB = BYTE_W - PRIO_W;

    ctl_t                ctl;
    dec_t                dec;
    exit_code_e          code;
    logic [BYTE_W-1:0]   page_q;
    logic [PRIO_W-1:0]   native_q;
    logic [PRIO_W-1:0]   shadow_prio;
    logic                unused_thr_bits;

    assign ctl             = '{use_shadow: ctl_use_shadow, load_exit: ctl_load_exit,
                               store_exit: ctl_store_exit};
    assign unused_thr_bits = ^thresh_field[THR_W-1:PRIO_W];
    assign shadow_prio     = page_q[BYTE_W-1:PRIO_LSB];

    tpr_decode #(.PRIO_W(PRIO_W)) u_dec (
        .ctl   (ctl),
        .rd    (acc_rd),
        .wr    (acc_wr),
        .wdata (acc_wdata),
        .thr   (thresh_field[PRIO_W-1:0]),
        .dec   (dec)
    );

    assign code = exit_for(dec);

    tpr_store #(.BYTE_W(BYTE_W), .PRIO_W(PRIO_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .host_we  (host_wr),
        .host_val (host_wdata),
        .sh_we    (dec.act == ACT_WR_SHADOW),
        .sh_val   (acc_wdata),
        .nat_we   (dec.act == ACT_WR_NATIVE),
        .nat_val  (acc_wdata),
        .page_q   (page_q),
        .native_q (native_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            exit_pulse  <= 1'b0;
            exit_reason <= EXIT_NONE;
            acc_err     <= 1'b0;
        end else begin
            rd_valid    <= (dec.act == ACT_RD_SHADOW) || (dec.act == ACT_RD_NATIVE);
            rd_data     <= (dec.act == ACT_RD_SHADOW) ? shadow_prio :
                           (dec.act == ACT_RD_NATIVE) ? native_q : '0;
            exit_pulse  <= (code != EXIT_NONE);
            exit_reason <= code;
            acc_err     <= (dec.act == ACT_ERR);
        end
    end

    assign host_rdata = page_q;
    assign native_cr8 = native_q;

    p_store_exit_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && !acc_wr && ctl_store_exit) |=>
            (exit_pulse && exit_reason == 2'b01 && !rd_valid));

    p_shadow_read_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && !acc_wr && !ctl_store_exit && ctl_use_shadow) |=>
            (rd_valid && rd_data == $past(host_rdata[BYTE_W-1:PRIO_LSB])));

    p_load_exit_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && !acc_rd && ctl_load_exit && !host_wr) |=>
            ($stable(host_rdata) && $stable(native_cr8) && exit_reason == 2'b10));

    p_trap_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && !acc_rd && !ctl_load_exit && ctl_use_shadow && !host_wr &&
         acc_wdata < thresh_field[PRIO_W-1:0]) |=>
            (exit_pulse && exit_reason == 2'b11 &&
             host_rdata[BYTE_W-1:PRIO_LSB] == $past(acc_wdata)));

    p_conflict_r9: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && acc_wr && !host_wr) |=>
            (acc_err && !exit_pulse && !rd_valid && $stable(host_rdata) && $stable(native_cr8)));

    p_reason_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !exit_pulse |-> (exit_reason == 2'b00));

    p_rd_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0));

endmodule

// File: tb/tpr_shadow_ctrl_bench.sv
`timescale 1ns/1ps
module tpr_shadow_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        us, le, se;
    logic [31:0] th;
    logic        rd, wr;
    logic [3:0]  wd;
    logic        rd_valid;
    logic [3:0]  rd_data;
    logic        exit_pulse;
    logic [1:0]  exit_reason;
    logic        acc_err;
    logic        hw;
    logic [7:0]  hd;
    logic [7:0]  host_rdata;
    logic [3:0]  native_cr8;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [7:0] m_byte;
    logic [3:0] m_nat;

    always #2 clk = ~clk;

    tpr_shadow_ctrl u_tpr_shadow_ctrl (
        .clk(clk), .rst(rst),
        .ctl_use_shadow(us), .ctl_load_exit(le), .ctl_store_exit(se),
        .thresh_field(th), .acc_rd(rd), .acc_wr(wr), .acc_wdata(wd),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .exit_pulse(exit_pulse), .exit_reason(exit_reason), .acc_err(acc_err),
        .host_wr(hw), .host_wdata(hd), .host_rdata(host_rdata),
        .native_cr8(native_cr8)
    );

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit r, bit w, logic [3:0] d, bit u, bit l, bit s,
                        logic [31:0] t, bit h, logic [7:0] hv);
        logic [7:0] nb;
        logic [3:0] nn;
        bit e_rdv, e_ex, e_err;
        logic [3:0] e_rdd;
        logic [1:0] e_rs;
        rd = r; wr = w; wd = d; us = u; le = l; se = s; th = t; hw = h; hd = hv;
        check(tag, "host_rdata", host_rdata, m_byte);
        e_rdv = 0; e_ex = 0; e_err = 0; e_rdd = 0; e_rs = 0;
        nb = m_byte; nn = m_nat;
        if (r && w) e_err = 1;
        else if (r) begin
            if (s)      begin e_ex = 1; e_rs = 2'd1; end
            else if (u) begin e_rdv = 1; e_rdd = m_byte[7:4]; end
            else        begin e_rdv = 1; e_rdd = m_nat; end
        end else if (w) begin
            if (l)      begin e_ex = 1; e_rs = 2'd2; end
            else if (u) begin
                nb = {d, m_byte[3:0]};
                if (d < t[3:0]) begin e_ex = 1; e_rs = 2'd3; end
            end else nn = d;
        end
        if (h) nb = hv;
        @(posedge clk);
        @(negedge clk);
        m_byte = nb; m_nat = nn;
        check(tag, "rd_valid",    {7'd0, rd_valid},   {7'd0, e_rdv});
        check(tag, "rd_data",     {4'd0, rd_data},    {4'd0, e_rdd});
        check(tag, "exit_pulse",  {7'd0, exit_pulse}, {7'd0, e_ex});
        check(tag, "exit_reason", {6'd0, exit_reason},{6'd0, e_rs});
        check(tag, "acc_err",     {7'd0, acc_err},    {7'd0, e_err});
        check(tag, "host_rdata",  host_rdata,         m_byte);
        check(tag, "native_cr8",  {4'd0, native_cr8}, {4'd0, m_nat});
        rd = 0; wr = 0; hw = 0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        rst = 1; rd = 0; wr = 0; wd = 0; us = 0; le = 0; se = 0; th = 0; hw = 0; hd = 0;
        m_byte = 0; m_nat = 0;
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1", "host_rdata", host_rdata, 8'h00);
        check("R1", "native_cr8", {4'd0, native_cr8}, 8'h00);
        check("R1", "exit", {5'd0, exit_pulse, exit_reason}, 8'h00);
        check("R1", "rd", {3'd0, rd_valid, rd_data}, 8'h00);
        check("R1", "acc_err", {7'd0, acc_err}, 8'h00);
        // R10: host write and readback
        step("R10", 0, 0, 4'h0, 1, 0, 0, 32'h0, 1, 8'hA5);
        // R4: shadowed read
        step("R4",  1, 0, 4'h0, 1, 0, 0, 32'h0, 0, 8'h00);
        // R3: store exit regardless of use-shadow
        step("R3",  1, 0, 4'h0, 1, 0, 1, 32'h0, 0, 8'h00);
        step("R3",  1, 0, 4'h0, 0, 0, 1, 32'h0, 0, 8'h00);
        // R11: pulse drops after idle
        step("R11", 0, 0, 4'h0, 1, 0, 0, 32'h0, 0, 8'h00);
        // R6: shadowed write keeps low nibble
        step("R6",  0, 1, 4'h7, 1, 0, 0, 32'h3, 0, 8'h00);
        step("R6",  1, 0, 4'h0, 1, 0, 0, 32'h3, 0, 8'h00);
        // R7 / R2: trap boundary with upper threshold bits set
        step("R7",  0, 1, 4'h1, 1, 0, 0, 32'hFFFF_FFF2, 0, 8'h00);
        step("R7",  0, 1, 4'h2, 1, 0, 0, 32'hFFFF_FFF2, 0, 8'h00);
        step("R2",  0, 1, 4'h0, 1, 0, 0, 32'h0000_0010, 0, 8'h00);
        step("R2",  0, 1, 4'hE, 1, 0, 0, 32'h8000_000F, 0, 8'h00);
        // R5: load exit leaves state
        step("R5",  0, 1, 4'h3, 1, 1, 0, 32'h0, 0, 8'h00);
        step("R5",  0, 1, 4'h9, 0, 1, 0, 32'h0, 0, 8'h00);
        // R8: native path
        step("R8",  0, 1, 4'hB, 0, 0, 0, 32'hF, 0, 8'h00);
        step("R8",  1, 0, 4'h0, 0, 0, 0, 32'hF, 0, 8'h00);
        // R9: conflicting request
        step("R9",  1, 1, 4'h4, 1, 0, 0, 32'hF, 0, 8'h00);
        step("R9",  1, 1, 4'h4, 0, 0, 0, 32'hF, 0, 8'h00);
        // R10: host beats guest shadow write, trap still raised
        step("R10", 0, 1, 4'h1, 1, 0, 0, 32'h5, 1, 8'h3C);
        // R11: back-to-back exits then quiet
        step("R11", 0, 1, 4'h0, 1, 1, 0, 32'h0, 0, 8'h00);
        step("R11", 1, 0, 4'h0, 1, 0, 1, 32'h0, 0, 8'h00);
        step("R11", 0, 0, 4'h0, 1, 0, 0, 32'h0, 0, 8'h00);
        // mixed patterns covering R2/R3/R4/R5/R6/R7/R8/R9/R10
        lf = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step("R2/R3/R4/R5/R6/R7/R8/R9/R10", lf[0], lf[1], lf[5:2], lf[6] | lf[7],
                 lf[8] & lf[9], lf[10] & lf[11], {lf, 12'h0, lf[15:12]},
                 lf[12] & lf[13] & lf[14], lf[15:8]);
        end
        // R1: reset mid-run clears everything
        rst = 1;
        @(negedge clk);
        rst = 0;
        m_byte = 0; m_nat = 0;
        check("R1", "host_rdata", host_rdata, 8'h00);
        check("R1", "native_cr8", {4'd0, native_cr8}, 8'h00);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule